// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 20-bit virtual address into a 16-bit physical address by walking a two-level forward-mapped page table held in memory. The page number is split into an upper index and a lower index. The upper index is added to a table base input to locate a first-level entry. That entry supplies the base of a second-level table, and the lower index is added to that base to locate the entry holding the frame number. The frame number is joined to the unchanged 10-bit page offset to form the physical address. If either entry is marked not present, the walk ends with a fault and a level indication instead.

A requester presents an address when the walker is idle. The walker then issues at most two dependent single-word reads on a memory port that answers after any latency. It reports the result with a one-cycle completion pulse. The walker is a state machine with six states: `WALK_IDLE`, `WALK_L1_REQ`, `WALK_L1_WAIT`, `WALK_L2_REQ`, `WALK_L2_WAIT` and `WALK_DONE`. Its transitions are as follows:
- IDLE goes to L1_REQ when a request is accepted.
- L1_REQ goes to L1_WAIT unconditionally.
- L1_WAIT goes to L2_REQ when the returned entry is present, or to DONE when it is absent.
- L2_REQ goes to L2_WAIT unconditionally.
- L2_WAIT goes to DONE on read data.
- DONE goes to IDLE unconditionally.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_rd_en` and `done_valid` are all 0.
- R2: The first read targets word address `pt_base + va[19:15]`, truncated to 12 bits.
- R3: The second read targets word address `E1[11:0] + va[14:10]`, truncated to 12 bits, where E1 is the first-level entry that was returned.
- R4: On a successful walk, `done_paddr` = {`E2[5:0]`, `va[9:0]`}, where E2 is the second-level entry, and `done_fault` is 0.
- R5: Each read is a single-cycle `mem_rd_en` pulse. No new read is issued until `mem_rd_valid` has answered the previous one, so a successful walk makes exactly two reads.
- R6: A first-level entry whose bit 15 (present) is 0 ends the walk after exactly one read. The result is `done_fault`=1, `done_fault_lvl`=0 and `done_paddr`=0.
- R7: A second-level entry whose bit 15 is 0 ends the walk with `done_fault`=1, `done_fault_lvl`=1 and `done_paddr`=0.
- R8: A request is accepted only while idle. `busy` is 1 from the cycle after acceptance until completion. `done_valid` is a single-cycle pulse. A `req_valid` raised while busy has no effect on the result or on the number of reads.
- R9: The walker tolerates any read latency of at least one cycle. A `mem_rd_valid` that arrives outside a wait state is ignored: while idle it causes no read, no completion and no busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, taken when idle |
| req_vaddr | input | 20 | Virtual address to translate |
| pt_base | input | 12 | Word address of the first-level table |
| busy | output | 1 | Walk in progress |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_addr | output | 12 | Word address of the read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 16 | Table entry: bit 15 present, low bits base or frame |
| done_valid | output | 1 | Result pulse |
| done_paddr | output | 16 | Physical address |
| done_fault | output | 1 | Walk ended on an absent entry |
| done_fault_lvl | output | 1 | 0 = first level absent, 1 = second level absent |

## Verification
The assertions assume that the memory returns exactly one `mem_rd_valid` for each read. They also assume that this response comes no earlier than the cycle after the `mem_rd_en` pulse. The bench memory model keeps a single outstanding read and responds after a programmable latency of one or more cycles. A stray `mem_rd_valid` is injected only while the walker is idle, where it is defined to be ignored. The request inputs are driven on the falling edge, and `req_vaddr` and `pt_base` are held until acceptance.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        WALK_IDLE,
        WALK_L1_REQ,
        WALK_L1_WAIT,
        WALK_L2_REQ,
        WALK_L2_WAIT,
        WALK_DONE
    } walk_state_t;
endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
    parameter int ED_W    = 16,
    parameter int MA_W    = 12,
    parameter int FRAME_W = 6
) (
    input  logic [ED_W-1:0]    entry,
    output logic               ent_present,
    output logic [MA_W-1:0]    ent_base,
    output logic [FRAME_W-1:0] ent_frame
);
    localparam int PRESENT_BIT = ED_W - 1;

    always_comb begin
        ent_present = entry[PRESENT_BIT];
        ent_base    = entry[MA_W-1:0];
        ent_frame   = entry[FRAME_W-1:0];
    end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic mem_rd_valid,
    input  logic ent_present,
    output logic busy,
    output logic mem_rd_en,
    output logic sel_l2,
    output logic take_req,
    output logic take_l1,
    output logic take_l2,
    output logic done_valid
);
    walk_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            WALK_IDLE:    if (req_valid) state_nx = WALK_L1_REQ;
            WALK_L1_REQ:  state_nx = WALK_L1_WAIT;
            WALK_L1_WAIT: if (mem_rd_valid)
                              state_nx = ent_present ? WALK_L2_REQ : WALK_DONE;
            WALK_L2_REQ:  state_nx = WALK_L2_WAIT;
            WALK_L2_WAIT: if (mem_rd_valid) state_nx = WALK_DONE;
            WALK_DONE:    state_nx = WALK_IDLE;
            default:      state_nx = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WALK_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        busy       = 1'b1;
        mem_rd_en  = 1'b0;
        sel_l2     = 1'b0;
        take_req   = 1'b0;
        take_l1    = 1'b0;
        take_l2    = 1'b0;
        done_valid = 1'b0;
        unique case (state)
            WALK_IDLE: begin
                busy     = 1'b0;
                take_req = req_valid;
            end
            WALK_L1_REQ:  mem_rd_en = 1'b1;
            WALK_L1_WAIT: take_l1 = mem_rd_valid;
            WALK_L2_REQ: begin
                mem_rd_en = 1'b1;
                sel_l2    = 1'b1;
            end
            WALK_L2_WAIT: begin
                sel_l2  = 1'b1;
                take_l2 = mem_rd_valid;
            end
            WALK_DONE:    done_valid = 1'b1;
            default:      busy = 1'b0;
        endcase
    end

    // R5: a read request never lasts two cycles
    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R8: accepting a request leads straight to the first read
    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (mem_rd_en && !sel_l2));

    // R9: completion only follows returned read data
    p_done_after_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(mem_rd_valid));
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath #(
    parameter int IDX1_W  = 5,
    parameter int IDX2_W  = 5,
    parameter int OFF_W   = 10,
    parameter int FRAME_W = 6,
    parameter int MA_W    = 12,
    localparam int VA_W   = IDX1_W + IDX2_W + OFF_W,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_req,
    input  logic               take_l1,
    input  logic               take_l2,
    input  logic               sel_l2,
    input  logic               done_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [MA_W-1:0]    pt_base,
    input  logic               ent_present,
    input  logic [MA_W-1:0]    ent_base,
    input  logic [FRAME_W-1:0] ent_frame,
    output logic [MA_W-1:0]    mem_addr,
    output logic [PA_W-1:0]    done_paddr,
    output logic               done_fault,
    output logic               done_fault_lvl
);
    localparam int IDX1_LO = IDX2_W + OFF_W;

    logic [VA_W-1:0] va_q;
    logic [MA_W-1:0] root_q;
    logic [MA_W-1:0] l2_base_q;
    logic [IDX1_W-1:0] idx1;
    logic [IDX2_W-1:0] idx2;
    logic [OFF_W-1:0]  offs;

    always_comb begin
        idx1 = va_q[VA_W-1:IDX1_LO];
        idx2 = va_q[IDX1_LO-1:OFF_W];
        offs = va_q[OFF_W-1:0];
        if (sel_l2) mem_addr = l2_base_q + MA_W'(idx2);
        else        mem_addr = root_q + MA_W'(idx1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q           <= '0;
            root_q         <= '0;
            l2_base_q      <= '0;
            done_paddr     <= '0;
            done_fault     <= 1'b0;
            done_fault_lvl <= 1'b0;
        end else if (take_req) begin
            va_q           <= req_vaddr;
            root_q         <= pt_base;
            done_paddr     <= '0;
            done_fault     <= 1'b0;
            done_fault_lvl <= 1'b0;
        end else if (take_l1) begin
            l2_base_q <= ent_base;
            if (!ent_present) begin
                done_fault     <= 1'b1;
                done_fault_lvl <= 1'b0;
            end
        end else if (take_l2) begin
            if (ent_present) begin
                done_paddr <= {ent_frame, offs};
            end else begin
                done_fault     <= 1'b1;
                done_fault_lvl <= 1'b1;
            end
        end
    end

    // R7: a level flag is only reported together with a fault
    p_lvl_implies_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault_lvl) |-> done_fault);

    // R6: a faulted result carries no address
    p_fault_zero_paddr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault) |-> (done_paddr == '0));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int IDX1_W  = 5,
    parameter int IDX2_W  = 5,
    parameter int OFF_W   = 10,
    parameter int FRAME_W = 6,
    parameter int MA_W    = 12,
    parameter int ED_W    = 16,
    localparam int VA_W   = IDX1_W + IDX2_W + OFF_W,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [MA_W-1:0] pt_base,
    output logic            busy,
    output logic            mem_rd_en,
    output logic [MA_W-1:0] mem_addr,
    input  logic            mem_rd_valid,
    input  logic [ED_W-1:0] mem_rd_data,
    output logic            done_valid,
    output logic [PA_W-1:0] done_paddr,
    output logic            done_fault,
    output logic            done_fault_lvl
);
    logic               ent_present;
    logic [MA_W-1:0]    ent_base;
    logic [FRAME_W-1:0] ent_frame;
    logic               sel_l2, take_req, take_l1, take_l2;

    ptw_entry_decode #(.ED_W(ED_W), .MA_W(MA_W), .FRAME_W(FRAME_W)) u_dec (
        .entry       (mem_rd_data),
        .ent_present (ent_present),
        .ent_base    (ent_base),
        .ent_frame   (ent_frame)
    );

    ptw_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .mem_rd_valid (mem_rd_valid),
        .ent_present  (ent_present),
        .busy         (busy),
        .mem_rd_en    (mem_rd_en),
        .sel_l2       (sel_l2),
        .take_req     (take_req),
        .take_l1      (take_l1),
        .take_l2      (take_l2),
        .done_valid   (done_valid)
    );

    ptw_datapath #(
        .IDX1_W(IDX1_W), .IDX2_W(IDX2_W), .OFF_W(OFF_W),
        .FRAME_W(FRAME_W), .MA_W(MA_W)
    ) u_dp (
        .clk            (clk),
        .rst_n          (rst_n),
        .take_req       (take_req),
        .take_l1        (take_l1),
        .take_l2        (take_l2),
        .sel_l2         (sel_l2),
        .done_valid     (done_valid),
        .req_vaddr      (req_vaddr),
        .pt_base        (pt_base),
        .ent_present    (ent_present),
        .ent_base       (ent_base),
        .ent_frame      (ent_frame),
        .mem_addr       (mem_addr),
        .done_paddr     (done_paddr),
        .done_fault     (done_fault),
        .done_fault_lvl (done_fault_lvl)
    );
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_vaddr = '0;
    logic [11:0] pt_base = '0;
    logic        busy, mem_rd_en, done_valid, done_paddr_f, done_fault, done_fault_lvl;
    logic [11:0] mem_addr;
    logic [15:0] done_paddr;
    logic        mv = 1'b0, stray = 1'b0, mem_rd_valid;
    logic [15:0] mem_rd_data = '0;

    always #10 clk = ~clk;   // 50 MHz

    assign mem_rd_valid = mv | stray;
    assign done_paddr_f = 1'b0;

    ptw_walker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .pt_base(pt_base), .busy(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .done_valid(done_valid), .done_paddr(done_paddr), .done_fault(done_fault),
        .done_fault_lvl(done_fault_lvl)
    );

    logic [15:0] mem [256];
    int lat = 1;
    int cnt = 0;
    bit pend = 1'b0;
    logic [11:0] pa_q = '0;
    int rd_cnt = 0;
    logic [11:0] rd_addr [4];
    int overlap = 0;
    int n_chk = 0, n_fail = 0;

    always @(posedge clk) begin
        mv <= 1'b0;
        if (pend) begin
            if (cnt <= 1) begin
                mv <= 1'b1;
                mem_rd_data <= mem[pa_q[7:0]];
                pend <= 1'b0;
            end else cnt <= cnt - 1;
        end
        if (mem_rd_en) begin
            if (pend) overlap <= overlap + 1;
            pend <= 1'b1;
            cnt  <= lat;
            pa_q <= mem_addr;
            if (rd_cnt < 4) rd_addr[rd_cnt] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    logic [15:0] r_pa;
    logic r_f, r_l;

    task automatic walk(input logic [19:0] va, input logic [11:0] base, input bit poke);
        int w;
        rd_cnt = 0; overlap = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; pt_base = base;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        if (poke) begin
            @(negedge clk);
            req_valid = 1'b1; req_vaddr = ~va; pt_base = base + 12'h5;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        w = 0;
        while (!done_valid && w < 200) begin @(negedge clk); w++; end
        chk(done_valid == 1'b1, "R9 completion reached", done_valid, 1);
        r_pa = done_paddr; r_f = done_fault; r_l = done_fault_lvl;
        @(negedge clk);
        chk(done_valid == 1'b0 && busy == 1'b0, "R8 done single pulse then idle", {done_valid, busy}, 0);
        chk(overlap == 0, "R5 no read while one outstanding", overlap, 0);
    endtask

    task automatic t_ok_basic();
        lat = 1;
        walk({5'd3, 5'd2, 10'h155}, 12'h010, 1'b0);
        chk(rd_cnt == 2, "R5 two reads", rd_cnt, 2);
        chk(rd_addr[0] == 12'h013, "R2 first address", rd_addr[0], 12'h013);
        chk(rd_addr[1] == 12'h042, "R3 second address", rd_addr[1], 12'h042);
        chk(r_pa == {6'h2A, 10'h155} && !r_f, "R4 physical address", r_pa, {6'h2A, 10'h155});
    endtask

    task automatic t_ok_slow_edges();
        lat = 5;
        walk({5'd7, 5'd31, 10'h3FF}, 12'h010, 1'b0);
        chk(rd_addr[0] == 12'h017, "R2 first address idx 7", rd_addr[0], 12'h017);
        chk(rd_addr[1] == 12'h09F, "R3 second address max idx", rd_addr[1], 12'h09F);
        chk(r_pa == 16'hFFFF && !r_f, "R9 R4 long latency result", r_pa, 16'hFFFF);
    endtask

    task automatic t_l1_fault();
        lat = 2;
        walk({5'd9, 5'd1, 10'h001}, 12'h010, 1'b0);
        chk(rd_cnt == 1, "R6 single read on first-level fault", rd_cnt, 1);
        chk(r_f && !r_l && r_pa == 0, "R6 fault level 0", {r_f, r_l, r_pa}, {2'b10, 16'h0});
    endtask

    task automatic t_l2_fault();
        lat = 3;
        walk({5'd3, 5'd5, 10'h0AA}, 12'h010, 1'b0);
        chk(rd_addr[1] == 12'h045, "R3 second address fault case", rd_addr[1], 12'h045);
        chk(r_f && r_l && r_pa == 0, "R7 fault level 1", {r_f, r_l, r_pa}, {2'b11, 16'h0});
    endtask

    task automatic t_other_base();
        lat = 1;
        walk({5'd7, 5'd2, 10'h000}, 12'h00C, 1'b0);
        chk(rd_addr[0] == 12'h013, "R2 base register used", rd_addr[0], 12'h013);
        chk(r_pa == {6'h2A, 10'h000}, "R4 result via other base", r_pa, {6'h2A, 10'h000});
    endtask

    task automatic t_busy_ignore();
        lat = 4;
        walk({5'd3, 5'd2, 10'h2F0}, 12'h010, 1'b1);
        chk(rd_cnt == 2, "R8 request while busy adds no read", rd_cnt, 2);
        chk(r_pa == {6'h2A, 10'h2F0} && !r_f, "R8 request while busy ignored", r_pa, {6'h2A, 10'h2F0});
    endtask

    task automatic t_stray_valid();
        bit bad = 1'b0;
        rd_cnt = 0;
        @(negedge clk);
        stray = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (busy || mem_rd_en || done_valid) bad = 1'b1;
        end
        stray = 1'b0;
        @(negedge clk);
        if (busy || mem_rd_en || done_valid) bad = 1'b1;
        chk(!bad && rd_cnt == 0, "R9 stray read data ignored while idle", {bad, rd_cnt[7:0]}, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[8'h13] = 16'h8040;
        mem[8'h17] = 16'h8080;
        mem[8'h19] = 16'h0040;
        mem[8'h42] = 16'h802A;
        mem[8'h45] = 16'h0015;
        mem[8'h9F] = 16'h803F;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_rd_en && !done_valid, "R1 reset idle", {busy, mem_rd_en, done_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_rd_en && !done_valid, "R1 idle after reset release", {busy, mem_rd_en, done_valid}, 0);
        t_ok_basic();
        t_ok_slow_edges();
        t_l1_fault();
        t_l2_fault();
        t_other_base();
        t_busy_ignore();
        t_stray_valid();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule